// File: doc/BRIEF.md
# Interleaved Gascon-Style Permutation Round Engine

This block applies between 1 and 12 rounds of a 320-bit substitution-permutation to a state of five 64-bit words. Each word is held in bit-interleaved form: its even-numbered bits form a 32-bit even half and its odd-numbered bits form a 32-bit odd half. A round has three steps. A round constant is added, then a five-input bitwise substitution runs on each half, then a per-word linear mix XORs each word with two rotated copies of itself. In the interleaved form, every 64-bit rotation reduces to two 32-bit rotations and, for odd amounts, a swap of the two halves.

While the rounds run, the engine folds selected halves of the state into a 128-bit accumulator after every round. A start pulse loads the state and the round count. The engine then completes one round per clock and pulses done. The final state and the accumulator stay readable until the next accepted start.

Top module: `gascon_engine`

## Requirements
- R1: A start sampled while the engine is idle loads the state from `state_in` and clears `r_out` to zero. In the next cycle `busy` is high and `state_out` equals the loaded state. Word i occupies bits [64i+63:64i]: its even half is in the low 32 bits and its odd half in the high 32 bits. Bit j of a half is bit 2j (even half) or bit 2j+1 (odd half) of the 64-bit word.
- R2: The effective round count n is `rounds`. A value of 0 or above 12 is treated as 12. `done` rises n clock edges after the edge that accepts start.
- R3: In the round with step index s (0 for the first round), the byte ((15-s)<<4)|s is XORed into bits [7:0] of the even half of word 2, before the substitution.
- R4: The substitution applies independently to every bit position of both halves: x0^=x4, x4^=x3, x2^=x1; ti = ~xi & x(i+1 mod 5); xi ^= t(i+1 mod 5); then x1^=x0, x0^=x4, x3^=x2, x2=~x2.
- R5: The linear layer sets each word w ^= rotr64(w,a) ^ rotr64(w,b). The (a,b) pairs by word index are 0:(28,19), 1:(38,61), 2:(6,1), 3:(10,17), 4:(40,7). Rotation acts on the 64-bit value that the interleaved halves represent.
- R6: After every round, with halves taken from the updated state: r0 ^= w0.even ^ w2.odd, r1 ^= w0.odd ^ w3.even, r2 ^= w1.even ^ w3.odd, r3 ^= w1.odd ^ w2.even. Word rk sits at `r_out` bits [32k+31:32k].
- R7: `busy` is high from the accepting edge to the last round edge. `done` is high for exactly one cycle, while `busy` is low.
- R8: While idle and without a start, `state_out` and `r_out` hold their values.
- R9: A start or a change of `state_in`/`rounds` while busy has no effect on the running computation or its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| rounds | input | 4 | Requested round count |
| state_in | input | 320 | Interleaved state to load |
| state_out | output | 320 | Current interleaved state |
| r_out | output | 128 | Round accumulator r3..r0 |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse after the last round |

## Verification
The loaded state and the cleared accumulator are due in the cycle after the edge that samples start. The final state and accumulator are due together with `done`, which comes n edges after that edge. The scoreboard records the cycle of each start and checks the elapsed count when the monitor sees `done`. It also compares the state and accumulator against a model that works on plain 64-bit words and converts to and from the interleaved form. Hold and ignore checks sample the outputs several idle cycles after `done`. All sampling happens on falling edges, away from the edges where registers update.

// File: rtl/gascon_pkg.sv
package gascon_pkg;

  localparam int HALF_W = 32;
  localparam int NWORDS = 5;
  localparam int ACC_WORDS = 4;

  typedef struct packed {
    logic [HALF_W-1:0] odd;
    logic [HALF_W-1:0] even;
  } ilw_t;

  typedef ilw_t [NWORDS-1:0] state_t;
  typedef logic [NWORDS-1:0][HALF_W-1:0] lane_t;
  typedef logic [ACC_WORDS-1:0][HALF_W-1:0] acc_t;

  localparam int unsigned ROT_A [NWORDS] = '{28, 38, 6, 10, 40};
  localparam int unsigned ROT_B [NWORDS] = '{19, 61, 1, 17, 7};

  function automatic logic [HALF_W-1:0] rotr_h(input logic [HALF_W-1:0] x,
                                                input int unsigned n);
    int unsigned sh;
    sh = n % HALF_W;
    if (sh == 0) return x;
    return (x >> sh) | (x << (HALF_W - sh));
  endfunction

  // 64-bit rotate expressed on interleaved halves
  function automatic ilw_t rotr_il(input ilw_t w, input int unsigned n);
    ilw_t o;
    int unsigned k;
    k = n / 2;
    if ((n % 2) == 0) begin
      o.even = rotr_h(w.even, k);
      o.odd  = rotr_h(w.odd, k);
    end else begin
      o.even = rotr_h(w.odd, k);
      o.odd  = rotr_h(w.even, k + 1);
    end
    return o;
  endfunction

  function automatic ilw_t mix_word(input ilw_t w, input int unsigned a,
                                    input int unsigned b);
    ilw_t ra;
    ilw_t rb;
    ilw_t o;
    ra = rotr_il(w, a);
    rb = rotr_il(w, b);
    o.even = w.even ^ ra.even ^ rb.even;
    o.odd  = w.odd ^ ra.odd ^ rb.odd;
    return o;
  endfunction

  function automatic logic [7:0] round_const(input logic [3:0] s);
    return {4'hF - s, s};
  endfunction

  function automatic lane_t sbox_lane(input lane_t x);
    lane_t c;
    lane_t t;
    c = x;
    c[0] = c[0] ^ c[4];
    c[4] = c[4] ^ c[3];
    c[2] = c[2] ^ c[1];
    for (int i = 0; i < NWORDS; i++) begin
      t[i] = ~c[i] & c[(i + 1) % NWORDS];
    end
    for (int i = 0; i < NWORDS; i++) begin
      c[i] = c[i] ^ t[(i + 1) % NWORDS];
    end
    c[1] = c[1] ^ c[0];
    c[0] = c[0] ^ c[4];
    c[3] = c[3] ^ c[2];
    c[2] = ~c[2];
    return c;
  endfunction

endpackage

// File: rtl/gascon_round.sv
module gascon_round
  import gascon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  state_t           cur,
  input  logic [CNT_W-1:0] step,
  output state_t           nxt
);

  state_t with_const;
  lane_t  ev_in;
  lane_t  od_in;
  lane_t  ev_out;
  lane_t  od_out;
  state_t mid;

  always_comb begin
    with_const = cur;
    with_const[2].even[7:0] = cur[2].even[7:0] ^ round_const(4'(step));
  end

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_split
    assign ev_in[gi] = with_const[gi].even;
    assign od_in[gi] = with_const[gi].odd;
  end

  assign ev_out = sbox_lane(ev_in);
  assign od_out = sbox_lane(od_in);

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_mix
    assign mid[gi].even = ev_out[gi];
    assign mid[gi].odd  = od_out[gi];
    assign nxt[gi] = mix_word(mid[gi], ROT_A[gi], ROT_B[gi]);
  end

endmodule

// File: rtl/gascon_fold.sv
module gascon_fold
  import gascon_pkg::*;
(
  input  state_t st,
  input  acc_t   acc_in,
  output acc_t   acc_out
);

  assign acc_out[0] = acc_in[0] ^ st[0].even ^ st[2].odd;
  assign acc_out[1] = acc_in[1] ^ st[0].odd ^ st[3].even;
  assign acc_out[2] = acc_in[2] ^ st[1].even ^ st[3].odd;
  assign acc_out[3] = acc_in[3] ^ st[1].odd ^ st[2].even;

endmodule

// File: rtl/gascon_ctrl.sv
module gascon_ctrl #(
  parameter int ROUND_LIMIT = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rounds,
  output logic             accept,
  output logic             round_fire,
  output logic             last_round,
  output logic [CNT_W-1:0] step,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ROUND_LIMIT);

  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] eff;

  always_comb begin
    if (rounds == '0 || rounds > LIMIT) eff = LIMIT;
    else eff = rounds;
  end

  assign accept     = start & ~busy;
  assign round_fire = busy;
  assign last_round = busy && (step == total_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step    <= '0;
      total_q <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      step    <= '0;
      total_q <= eff;
    end else if (busy) begin
      if (last_round) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        step <= step + 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/gascon_engine.sv
module gascon_engine
  import gascon_pkg::*;
#(
  parameter int ROUND_LIMIT = 12,
  localparam int CNT_W = $clog2(ROUND_LIMIT + 1),
  localparam int STATE_W = NWORDS * 2 * HALF_W,
  localparam int ACC_W = ACC_WORDS * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   rounds,
  input  logic [STATE_W-1:0] state_in,
  output logic [STATE_W-1:0] state_out,
  output logic [ACC_W-1:0]   r_out,
  output logic               busy,
  output logic               done
);

  logic             accept;
  logic             round_fire;
  logic             last_round;
  logic [CNT_W-1:0] step;

  state_t st_q;
  state_t st_next;
  acc_t   acc_q;
  acc_t   acc_next;

  gascon_ctrl #(
    .ROUND_LIMIT(ROUND_LIMIT),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .start(start),
    .rounds(rounds),
    .accept(accept),
    .round_fire(round_fire),
    .last_round(last_round),
    .step(step),
    .busy(busy),
    .done(done)
  );

  gascon_round #(.CNT_W(CNT_W)) u_round (
    .cur(st_q),
    .step(step),
    .nxt(st_next)
  );

  gascon_fold u_fold (
    .st(st_next),
    .acc_in(acc_q),
    .acc_out(acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      acc_q <= '0;
    end else if (accept) begin
      st_q  <= state_t'(state_in);
      acc_q <= '0;
    end else if (round_fire) begin
      st_q  <= st_next;
      acc_q <= acc_next;
    end
  end

  assign state_out = st_q;
  assign r_out     = acc_q;

endmodule

// File: rtl/gascon_engine_chk.sv
module gascon_engine_chk #(
  parameter int CNT_W = 4,
  parameter int STATE_W = 320,
  parameter int ACC_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               round_fire,
  input logic               last_round,
  input logic [CNT_W-1:0]   step,
  input logic [STATE_W-1:0] state_out,
  input logic [ACC_W-1:0]   r_out
);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done only while idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1: accepted start clears the accumulator and raises busy
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && r_out == '0));

  // R2: last round is followed by done
  a_r2_last_done: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> done);

  // R3: step index advances by one per non-final round
  a_r3_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (round_fire && !last_round) |=> (step == $past(step) + 1'b1));

  // R8: idle without start holds the results
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(state_out) && $stable(r_out)));

endmodule

bind gascon_engine gascon_engine_chk #(
  .CNT_W(CNT_W),
  .STATE_W(STATE_W),
  .ACC_W(ACC_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .start(start),
  .busy(busy),
  .done(done),
  .round_fire(round_fire),
  .last_round(last_round),
  .step(step),
  .state_out(state_out),
  .r_out(r_out)
);

// File: tb/sim_gascon_engine.sv
module sim_gascon_engine;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   rounds = '0;
  logic [319:0] state_in = '0;
  logic [319:0] state_out;
  logic [127:0] r_out;
  logic         busy;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  bit prev_done = 0;

  typedef struct {
    logic [319:0] st;
    logic [127:0] r;
    int n;
    int t0;
  } item_t;

  item_t q[$];
  item_t got;
  logic [319:0] last_st = '0;
  logic [127:0] last_r = '0;

  gascon_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rounds(rounds),
    .state_in(state_in), .state_out(state_out), .r_out(r_out),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [319:0] act, input logic [319:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // plain 64-bit <-> interleaved {odd,even}
  function automatic logic [63:0] to_nat(input logic [63:0] w);
    logic [63:0] x;
    for (int j = 0; j < 32; j++) begin
      x[2*j]   = w[j];
      x[2*j+1] = w[32+j];
    end
    return x;
  endfunction

  function automatic logic [63:0] to_il(input logic [63:0] x);
    logic [63:0] w;
    for (int j = 0; j < 32; j++) begin
      w[j]    = x[2*j];
      w[32+j] = x[2*j+1];
    end
    return w;
  endfunction

  function automatic logic [63:0] rot_bits(input logic [63:0] x, input int n);
    logic [63:0] y;
    for (int b = 0; b < 64; b++) y[b] = x[(b + n) % 64];
    return y;
  endfunction

  function automatic void model(input logic [319:0] st, input int n,
                                output logic [319:0] so, output logic [127:0] ro);
    logic [63:0] x [5];
    logic [63:0] t [5];
    logic [63:0] il [5];
    logic [7:0] k;
    int ra [5];
    int rb [5];
    ra = '{28, 38, 6, 10, 40};
    rb = '{19, 61, 1, 17, 7};
    ro = '0;
    for (int i = 0; i < 5; i++) x[i] = to_nat(st[64*i +: 64]);
    for (int s = 0; s < n; s++) begin
      k = 8'(((15 - s) << 4) | s);
      for (int j = 0; j < 8; j++) x[2][2*j] = x[2][2*j] ^ k[j];
      x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
      for (int i = 0; i < 5; i++) t[i] = ~x[i] & x[(i + 1) % 5];
      for (int i = 0; i < 5; i++) x[i] ^= t[(i + 1) % 5];
      x[1] ^= x[0]; x[0] ^= x[4]; x[3] ^= x[2]; x[2] = ~x[2];
      for (int i = 0; i < 5; i++)
        x[i] = x[i] ^ rot_bits(x[i], ra[i]) ^ rot_bits(x[i], rb[i]);
      for (int i = 0; i < 5; i++) il[i] = to_il(x[i]);
      ro[31:0]   ^= il[0][31:0]  ^ il[2][63:32];
      ro[63:32]  ^= il[0][63:32] ^ il[3][31:0];
      ro[95:64]  ^= il[1][31:0]  ^ il[3][63:32];
      ro[127:96] ^= il[1][63:32] ^ il[2][31:0];
    end
    for (int i = 0; i < 5; i++) so[64*i +: 64] = to_il(x[i]);
  endfunction

  function automatic logic [319:0] rnd_state();
    logic [319:0] v;
    for (int i = 0; i < 10; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(0, "R7", "done wider than one cycle", 1, 0);
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R9", "done with no pending run", 1, 0);
        end else begin
          got = q.pop_front();
          chk(cyc - got.t0 == got.n + 1, "R2", "latency", cyc - got.t0, got.n + 1);
          chk(state_out == got.st, "R3 R4 R5", "final state", state_out, got.st);
          chk(r_out == got.r, "R6", "accumulator", r_out, got.r);
          last_st = got.st;
          last_r  = got.r;
        end
      end
      prev_done = done;
    end
  end

  task automatic run(input logic [3:0] rnd, input logic [319:0] st, input bit poke);
    item_t it;
    it.n = (rnd == 0 || rnd > 12) ? 12 : int'(rnd);
    model(st, it.n, it.st, it.r);
    @(negedge clk);
    rounds = rnd; state_in = st; start = 1'b1;
    it.t0 = cyc;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0; state_in = ~st; rounds = 4'd1;
    chk(busy, "R7", "busy after start", busy, 1);
    chk(state_out == st, "R1", "loaded state", state_out, st);
    chk(r_out == '0, "R1", "accumulator cleared", r_out, 0);
    if (poke) begin
      start = 1'b1; state_in = st ^ {10{32'h5a5a5a5a}};
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(state_out == last_st, "R8", "state held", state_out, last_st);
    chk(r_out == last_r, "R8", "accumulator held", r_out, last_r);
    chk(!done && !busy, "R7", "idle after done", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(state_out == '0 && r_out == '0, "R1", "reset outputs", state_out, 0);
    chk(!busy && !done, "R7", "reset flags", {busy, done}, 0);
    rst_n = 1'b1;
    run(4'd1, '0, 0);
    run(4'd1, rnd_state(), 0);
    run(4'd2, rnd_state(), 0);
    run(4'd6, '0, 0);
    run(4'd12, rnd_state(), 0);
    run(4'd0, rnd_state(), 0);   // R2 clamp of zero
    run(4'd15, '1, 0);           // R2 clamp above limit
    run(4'd13, rnd_state(), 0);
    run(4'd3, rnd_state(), 1);   // R9 start while busy
    run(4'd5, rnd_state(), 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule